// File: doc/BRIEF.md
# Edge-Kicked Watchdog with Selectable Timeout

This block keeps a system alive only while software keeps toggling a kick bit. A single 8-bit setup register is reached over a minimal bus (select, write strobe, write data, read data). Three bits of it pick the timeout, one bit is the kick, and one more bit is a separate active-low reset for a peripheral bus that the block simply drives out. The register's top three bits do not exist and read back as zero.

The counter advances once per clock while a timeout is selected. A change of the kick bit in either direction, or a new timeout code, sets it back to zero. If the count reaches the selected period with no such event, a reset pulse of fixed length is emitted, the count is held at zero during the pulse, and counting restarts when the pulse ends. Each period is a parameter given in clock cycles, so a bench can shorten the real delays. Select code 3'b011 turns the watchdog off, and that is the state after reset.

Top module: `kick_wdog`

## Requirements
- R1: After reset the register reads 8'h1B (bus reset released, kick bit high, select 3'b011), `wdRst` is low and `periphRstN` is high.
- R2: A read returns the last value written, with bits 7:5 forced to zero.
- R3: The register changes only on a clock edge where both `busSel` and `busWr` are high.
- R4: With select 3'b011 the watchdog is off and `wdRst` stays low however long the kick bit holds its level.
- R5: The period in cycles is chosen by bits 2:0: 000 PER_A, 001 PER_B, 010 PER_C, 100 PER_D, 101 PER_E, 110 PER_F, 111 PER_G. `wdRst` rises exactly that many cycles after the last clear.
- R6: A write that changes bit 3, whether rising or falling, clears the count, and does so even on the last cycle before expiry. A write that leaves bit 3 and bits 2:0 as they were does not clear it.
- R7: The reset pulse lasts PULSE_LEN cycles. The count restarts from zero when the pulse ends, so the pulse repeats every period if no kick arrives.
- R8: A write that changes bits 2:0 clears the count, so the new period is timed from that write.
- R9: Bit 4 drives `periphRstN` directly (0 asserts, 1 releases) and has no effect on the watchdog timing.
- R10: A kick written while the pulse is active neither shortens nor restarts the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register select |
| busWr | input | 1 | Write strobe, used together with busSel |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Register contents, bits 7:5 zero |
| periphRstN | output | 1 | Active-low peripheral bus reset taken from bit 4 |
| wdRst | output | 1 | Watchdog reset pulse, active high |

## Verification
The hardest case is the race at expiry, where a kick write lands on the very clock edge that would otherwise start the pulse. The stimulus counts negative edges from a known clear and issues the next kick so that its write edge falls on cycle PER_A. It also times a write of an unchanged value, a select change and a bus-reset change at fixed offsets, and a kick during the pulse. Periods are set to a few cycles so every code is checked in a short run, and a behavioural model is compared against the outputs on every clock.

// File: rtl/kick_wdog_pkg.sv
package kick_wdog_pkg;
  localparam logic [2:0] SEL_OFF   = 3'b011;
  localparam logic [7:0] SETUP_RST = 8'h1B;

  typedef struct packed {
    logic       clrCnt;
    logic       runEn;
    logic [2:0] selCode;
  } wdCtl_t;
endpackage

// File: rtl/kick_wdog_ctrl.sv
module kick_wdog_ctrl
  import kick_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       periphRstN,
  output wdCtl_t     ctl
);
  logic       kickQ;
  logic       brstQ;
  logic [2:0] selQ;
  logic       wrEn;
  logic       kickFlip;
  logic       selMove;

  assign wrEn     = busSel && busWr;
  assign kickFlip = wrEn && (busWrData[3] != kickQ);
  assign selMove  = wrEn && (busWrData[2:0] != selQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brstQ <= SETUP_RST[4];
      kickQ <= SETUP_RST[3];
      selQ  <= SETUP_RST[2:0];
    end else if (wrEn) begin
      brstQ <= busWrData[4];
      kickQ <= busWrData[3];
      selQ  <= busWrData[2:0];
    end
  end

  always_comb begin
    ctl.clrCnt  = kickFlip || selMove;
    ctl.runEn   = (selQ != SEL_OFF);
    ctl.selCode = selQ;
  end

  assign busRdData  = {3'b000, brstQ, kickQ, selQ};
  assign periphRstN = brstQ;

  p_brst_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (periphRstN == $past(busWrData[4])));

  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(busRdData));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (busRdData[4:0] == $past(busWrData[4:0])));
endmodule

// File: rtl/kick_wdog_dp.sv
module kick_wdog_dp
  import kick_wdog_pkg::*;
#(
  parameter int CNT_W = 33,
  parameter logic [CNT_W-1:0] PER_A = 100_000,
  parameter logic [CNT_W-1:0] PER_B = 1_000_000,
  parameter logic [CNT_W-1:0] PER_C = 3_000_000,
  parameter logic [CNT_W-1:0] PER_D = 10_000_000,
  parameter logic [CNT_W-1:0] PER_E = 100_000_000,
  parameter logic [CNT_W-1:0] PER_F = 1_000_000_000,
  parameter logic [CNT_W-1:0] PER_G = 33'd6_000_000_000,
  parameter int PULSE_LEN = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  wdCtl_t ctl,
  output logic   wdRst
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [PW-1:0]    pulseLeft;
  logic             expire;

  always_comb begin
    case (ctl.selCode)
      3'b000:  limit = PER_A;
      3'b001:  limit = PER_B;
      3'b010:  limit = PER_C;
      3'b100:  limit = PER_D;
      3'b101:  limit = PER_E;
      3'b110:  limit = PER_F;
      3'b111:  limit = PER_G;
      default: limit = '1;
    endcase
  end

  assign expire = (cnt + 1'b1) >= limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      pulseLeft <= '0;
    end else if (pulseLeft != '0) begin
      pulseLeft <= pulseLeft - 1'b1;
      cnt       <= '0;
    end else if (ctl.clrCnt || !ctl.runEn) begin
      cnt <= '0;
    end else if (expire) begin
      cnt       <= '0;
      pulseLeft <= PW'(PULSE_LEN);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wdRst = (pulseLeft != '0);

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !wdRst) |=> !wdRst);

  p_clear_no_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrCnt && !wdRst) |=> !wdRst);

  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.runEn |-> (cnt < limit));

  p_pulse_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRst) |-> (pulseLeft == PW'(PULSE_LEN)));

  p_pulse_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wdRst && pulseLeft > 1) |=> wdRst);
endmodule

// File: rtl/kick_wdog.sv
module kick_wdog
  import kick_wdog_pkg::*;
#(
  parameter int CNT_W = 33,
  parameter logic [CNT_W-1:0] PER_A = 100_000,
  parameter logic [CNT_W-1:0] PER_B = 1_000_000,
  parameter logic [CNT_W-1:0] PER_C = 3_000_000,
  parameter logic [CNT_W-1:0] PER_D = 10_000_000,
  parameter logic [CNT_W-1:0] PER_E = 100_000_000,
  parameter logic [CNT_W-1:0] PER_F = 1_000_000_000,
  parameter logic [CNT_W-1:0] PER_G = 33'd6_000_000_000,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       periphRstN,
  output logic       wdRst
);
  wdCtl_t ctl;

  kick_wdog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .periphRstN (periphRstN),
    .ctl        (ctl)
  );

  kick_wdog_dp #(
    .CNT_W     (CNT_W),
    .PER_A     (PER_A),
    .PER_B     (PER_B),
    .PER_C     (PER_C),
    .PER_D     (PER_D),
    .PER_E     (PER_E),
    .PER_F     (PER_F),
    .PER_G     (PER_G),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .wdRst (wdRst)
  );
endmodule

// File: tb/kick_wdog_tb.sv
module kick_wdog_tb;
  localparam int PL = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       periphRstN;
  logic       wdRst;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] cur = 8'h1B;

  logic [7:0] mReg = 8'h1B;
  int mCnt = 0;
  int mPulse = 0;
  bit mWr, mClr;

  always #5 clk = ~clk;

  kick_wdog #(
    .CNT_W(8), .PER_A(8'd6), .PER_B(8'd9), .PER_C(8'd12), .PER_D(8'd15),
    .PER_E(8'd18), .PER_F(8'd21), .PER_G(8'd24), .PULSE_LEN(PL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData),
    .periphRstN(periphRstN), .wdRst(wdRst)
  );

  function automatic int per(input logic [2:0] c);
    case (c)
      3'b000: return 6;
      3'b001: return 9;
      3'b010: return 12;
      3'b100: return 15;
      3'b101: return 18;
      3'b110: return 21;
      3'b111: return 24;
      default: return 1000000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, compared after every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 8'h1B; mCnt = 0; mPulse = 0;
    end else begin
      mWr  = busSel && busWr;
      mClr = mWr && ((busWrData[3] != mReg[3]) || (busWrData[2:0] != mReg[2:0]));
      if (mPulse > 0) begin mPulse--; mCnt = 0; end
      else if (mClr || mReg[2:0] == 3'b011) mCnt = 0;
      else if (mCnt + 1 >= per(mReg[2:0])) begin mCnt = 0; mPulse = PL; end
      else mCnt++;
      if (mWr) mReg = {3'b000, busWrData[4:0]};
    end
    #2;
    chk(busRdData == mReg, "R2 model read", busRdData, mReg);
    chk(wdRst == (mPulse > 0), "R5/R7 model pulse", wdRst, (mPulse > 0));
    chk(periphRstN == mReg[4], "R9 model bus reset", periphRstN, mReg[4]);
  end

  task automatic busWrite(input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    cur = {3'b000, d[4:0]};
  endtask

  task automatic kickSel(input logic [2:0] code);
    busWrite({3'b000, cur[4], ~cur[3], code});
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    while (!wdRst && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic pulseWidth(output int w);
    w = 0;
    while (wdRst && w < 50) begin @(negedge clk); w++; end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int n, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busRdData == 8'h1B, "R1 reset read", busRdData, 8'h1B);
    chk(wdRst == 1'b0, "R1 wdRst low", wdRst, 0);
    chk(periphRstN == 1'b1, "R1 bus reset released", periphRstN, 1);

    // R4 disabled after reset
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(!wdRst, "R4 off after reset", wdRst, 0);
    end

    // R3 write strobe without select is ignored
    busWr = 1'b1; busWrData = 8'h00;
    @(negedge clk);
    busWr = 1'b0;
    chk(busRdData == 8'h1B, "R3 no select no write", busRdData, 8'h1B);
    chk(periphRstN == 1'b1, "R3 bus reset untouched", periphRstN, 1);
    busSel = 1'b1;
    @(negedge clk);
    busSel = 1'b0;
    chk(busRdData == 8'h1B, "R3 select without strobe", busRdData, 8'h1B);

    // R2 upper bits read zero, R9 bus reset asserted
    busWrite(8'hE3);
    chk(busRdData == 8'h03, "R2 upper bits zero", busRdData, 8'h03);
    chk(periphRstN == 1'b0, "R9 bus reset asserted", periphRstN, 0);
    busWrite(8'h1B);
    chk(busRdData == 8'h1B, "R2 readback", busRdData, 8'h1B);
    chk(periphRstN == 1'b1, "R9 bus reset released", periphRstN, 1);

    // R5 every code, R7 width and restart
    for (int k = 0; k < 8; k++) begin
      if (k == 3) continue;
      kickSel(3'(k));
      waitPulse(n);
      chk(n == per(3'(k)), "R5 period", n, per(3'(k)));
      pulseWidth(w);
      chk(w == PL, "R7 pulse width", w, PL);
      waitPulse(n);
      chk(n == per(3'(k)), "R7 restart period", n, per(3'(k)));
      pulseWidth(w);
    end

    // R6 kick on the last cycle before expiry
    kickSel(3'b000);
    repeat (6 - 2) @(negedge clk);
    kickSel(3'b000);
    waitPulse(n);
    chk(n == 6, "R6 last-cycle kick", n, 6);
    pulseWidth(w);

    // R6 write of unchanged value does not clear
    kickSel(3'b000);
    repeat (2) @(negedge clk);
    busWrite(cur);
    waitPulse(n);
    chk(n == 6 - 4, "R6 same value no clear", n, 2);
    pulseWidth(w);

    // R8 select change restarts timing
    kickSel(3'b000);
    repeat (2) @(negedge clk);
    busWrite({3'b000, cur[4:3], 3'b001});
    waitPulse(n);
    chk(n == 9, "R8 new period from change", n, 9);
    pulseWidth(w);

    // R9 bus reset bit does not touch timing
    busWrite({3'b000, 1'b1, ~cur[3], 3'b000});
    @(negedge clk);
    busWrite({3'b000, 1'b0, cur[3], 3'b000});
    chk(periphRstN == 1'b0, "R9 bus reset asserted", periphRstN, 0);
    waitPulse(n);
    chk(n == 6 - 3, "R9 no clear from bit 4", n, 3);
    pulseWidth(w);

    // R10 kick during pulse
    busWrite({3'b000, 1'b1, ~cur[3], 3'b000});
    waitPulse(n);
    kickSel(3'b000);
    pulseWidth(w);
    chk(2 + w == PL, "R10 pulse not cut", 2 + w, PL);
    waitPulse(n);
    chk(n == 6, "R10 restart after pulse", n, 6);
    pulseWidth(w);

    // R4 switch off again
    busWrite({3'b000, cur[4:3], 3'b011});
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(!wdRst, "R4 off by code", wdRst, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule